// File: doc/BRIEF.md
# Asynchronous Serial Transmit Engine

This block is the transmit half of an asynchronous serial port. A host pushes words into a one-entry holding buffer over a valid/ready handshake. When the transmitter is enabled and the buffer is full, the engine moves the word into a shift register and drives one frame on the line. The frame is a low start bit, then 7, 8 or 9 data bits, then an optional parity bit, then one or two high stop bits. The engine also honours an optional active-low clear-to-send input before it starts a frame.

Bit timing comes from a prescaler enable (`clk_en`) and an 8-bit divisor `m`. Each bit lasts 16×(m+1) enable pulses. Per-frame options are:
- bit order (least significant bit first, or most significant bit first);
- inversion of the data bits alone;
- parity mode.

An output-polarity option acts live on the pin and flips every level, framing bits included. A single-cycle interrupt pulse is raised either when a word leaves the holding buffer or when the last stop bit of a frame ends. Back-pressure rule: `wr_ready` is high exactly when the holding buffer is empty. A word is taken on a clock edge where `wr_valid` and `wr_ready` are both high. The host must hold `wr_data` stable while `wr_valid` is high and `wr_ready` is low.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset, `txd` sits at the idle level (1 XOR `cfg_line_inv`), `wr_ready` is 1, and both `tx_busy` and `irq` are 0.
- R2: A frame begins with a low start bit, followed by the data bits, then any parity bit, then high stop bits. With `cfg_msb_first`=0 the data leaves from bit 0 upward. `txd` changes in the cycle right after the clock edge that starts or advances the frame.
- R3: `cfg_data_len` selects the number of data bits: 0 gives 7, 1 gives 8, 2 gives 9, and 3 behaves as 8. Data bits above the selected length are ignored.
- R4: When `cfg_parity_en`=1, one parity bit follows the last data bit. It is computed over the data bits as transmitted, so after any data inversion. `cfg_parity_odd`=0 makes the count of ones over data and parity even; `cfg_parity_odd`=1 makes it odd.
- R5: `cfg_two_stop` selects one stop bit (0) or two stop bits (1).
- R6: Each bit lasts exactly 16×(`cfg_divisor`+1) cycles in which `clk_en` is high. Cycles with `clk_en` low do not advance the frame.
- R7: A frame starts only on an edge where all of these hold: the engine is idle, the buffer is full, `cfg_tx_en` is 1, and either `cfg_cts_en` is 0 or `cts_n` is 0. While `tx_busy` is high it stays high until the last stop bit ends.
- R8: With `cfg_msb_first`=1, the data leaves starting from its highest selected bit (bit 6, 7 or 8) down to bit 0.
- R9: `cfg_data_inv`=1 inverts only the data bits. The start, parity-rule and stop levels are unchanged.
- R10: `cfg_line_inv`=1 inverts the `txd` pin at all times, including idle, start and stop levels, and it takes effect immediately.
- R11: With `cfg_irq_on_done`=0, `irq` pulses for one cycle after the edge that moves a word into the shift register. With `cfg_irq_on_done`=1, it pulses for one cycle after the edge that ends the last stop bit.
- R12: The holding buffer empties (`wr_ready` rises) on the edge that starts the frame. A new word can be accepted while the frame is still on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Prescaled bit-clock enable |
| cfg_divisor | input | 8 | Divisor m; bit time is 16×(m+1) enables |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_data_len | input | 2 | Data length code (7/8/9 bits) |
| cfg_parity_en | input | 1 | Insert parity bit |
| cfg_parity_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_msb_first | input | 1 | Send highest data bit first |
| cfg_data_inv | input | 1 | Invert data bits only |
| cfg_line_inv | input | 1 | Invert whole output pin |
| cfg_cts_en | input | 1 | Gate frame start on clear-to-send |
| cfg_irq_on_done | input | 1 | Interrupt at frame end instead of buffer transfer |
| cts_n | input | 1 | Active-low clear-to-send |
| wr_valid | input | 1 | Host word valid |
| wr_data | input | 9 | Host word |
| wr_ready | output | 1 | Holding buffer empty / can accept |
| txd | output | 1 | Serial line output |
| tx_busy | output | 1 | A frame is on the line |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The host write handshake and the shift register's frame end can coincide. A word is offered while the previous frame is in its last stop bit, so the buffer fill and the frame finish can land on the same edge. The next start must then follow on the following edge, with the line returning to idle for one cycle. A second overlap comes from `cts_n`, `cfg_tx_en` and `cfg_line_inv` changing at that same instant or in the middle of a frame. A behavioural model of the frame, built as a queue of line levels, is compared against `txd`, `wr_ready`, `tx_busy` and `irq` on every cycle. Any skew in start timing, interrupt placement or buffer release therefore shows up as a miscompare.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int MAX_DATA = 9;
  localparam int FRAME_W  = 1 + MAX_DATA + 1 + 2;
  localparam int REM_W    = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
    logic       msb_first;
    logic       data_inv;
  } fmt_t;

  function automatic logic [3:0] data_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd7;
      2'd2:    return 4'd9;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W    = 8,
  parameter int OVS_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clk_en,
  input  logic [DIV_W-1:0] divisor,
  output logic             bit_end
);
  localparam int CNT_W = DIV_W + OVS_LOG2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit   = {divisor, {OVS_LOG2{1'b1}}};
  assign bit_end = run && clk_en && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (clk_en)   cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         take,
  output logic         hold_valid,
  output logic [W-1:0] hold_data
);
  assign wr_ready = !hold_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else if (take) begin
      hold_valid <= 1'b0;
    end else if (wr_valid && !hold_valid) begin
      hold_valid <= 1'b1;
      hold_data  <= wr_data;
    end
  end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_DATA-1:0] word,
  input  fmt_t                fmt,
  input  logic                bit_end,
  output logic                busy,
  output logic                line_bit,
  output logic                done
);
  logic [FRAME_W-1:0] frame_c;
  logic [FRAME_W-1:0] sh;
  logic [REM_W-1:0]   rem;
  logic [REM_W-1:0]   nbits_c;
  logic [3:0]         len_c;
  logic [3:0]         idx_c;
  logic               par_c;
  logic               b_c;

  assign len_c   = data_bits(fmt.len);
  assign nbits_c = REM_W'(len_c) + REM_W'(2) + REM_W'(fmt.par_en) + REM_W'(fmt.two_stop);
  assign done    = busy && bit_end && (rem == '0);

  always_comb begin
    frame_c    = '1;
    frame_c[0] = 1'b0;
    par_c      = 1'b0;
    idx_c      = '0;
    b_c        = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < int'(len_c)) begin
        idx_c        = fmt.msb_first ? (len_c - 4'd1 - 4'(i)) : 4'(i);
        b_c          = word[idx_c] ^ fmt.data_inv;
        frame_c[1+i] = b_c;
        par_c        = par_c ^ b_c;
      end
    end
    if (fmt.par_en) frame_c[len_c + 4'd1] = par_c ^ fmt.par_odd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '1;
      rem      <= '0;
      busy     <= 1'b0;
      line_bit <= 1'b1;
    end else if (load) begin
      sh       <= frame_c;
      rem      <= nbits_c - 1'b1;
      busy     <= 1'b1;
      line_bit <= 1'b0;
    end else if (busy && bit_end) begin
      if (rem == '0) begin
        busy     <= 1'b0;
        line_bit <= 1'b1;
      end else begin
        sh       <= {1'b1, sh[FRAME_W-1:1]};
        line_bit <= sh[1];
        rem      <= rem - 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_tx_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int OVS_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [DIV_W-1:0] cfg_divisor,
  input  logic             cfg_tx_en,
  input  logic [1:0]       cfg_data_len,
  input  logic             cfg_parity_en,
  input  logic             cfg_parity_odd,
  input  logic             cfg_two_stop,
  input  logic             cfg_msb_first,
  input  logic             cfg_data_inv,
  input  logic             cfg_line_inv,
  input  logic             cfg_cts_en,
  input  logic             cfg_irq_on_done,
  input  logic             cts_n,
  input  logic             wr_valid,
  input  logic [8:0]       wr_data,
  output logic             wr_ready,
  output logic             txd,
  output logic             tx_busy,
  output logic             irq
);
  logic                hold_valid;
  logic [MAX_DATA-1:0] hold_data;
  logic                start;
  logic                bit_end;
  logic                line_bit;
  logic                done;
  fmt_t                fmt;

  assign fmt = '{len: cfg_data_len, par_en: cfg_parity_en, par_odd: cfg_parity_odd,
                 two_stop: cfg_two_stop, msb_first: cfg_msb_first, data_inv: cfg_data_inv};

  assign start = !tx_busy && hold_valid && cfg_tx_en && (!cfg_cts_en || !cts_n);

  uart_tx_hold #(.W(MAX_DATA)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .take(start), .hold_valid(hold_valid), .hold_data(hold_data)
  );

  uart_tx_baud #(.DIV_W(DIV_W), .OVS_LOG2(OVS_LOG2)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(tx_busy), .clk_en(clk_en),
    .divisor(cfg_divisor), .bit_end(bit_end)
  );

  uart_tx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .load(start), .word(hold_data), .fmt(fmt),
    .bit_end(bit_end), .busy(tx_busy), .line_bit(line_bit), .done(done)
  );

  assign txd = line_bit ^ cfg_line_inv;

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= cfg_irq_on_done ? done : start;
  end
endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic clk_en,
  input logic cfg_tx_en,
  input logic cfg_cts_en,
  input logic cts_n,
  input logic cfg_line_inv,
  input logic wr_ready,
  input logic tx_busy,
  input logic txd,
  input logic irq
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> (txd == !cfg_line_inv)); // R10
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> (txd == cfg_line_inv)); // R2
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(cfg_tx_en)); // R7
  AST_START_NEEDS_CTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_busy) && $past(cfg_cts_en)) |-> !$past(cts_n)); // R7
  AST_BUF_FREED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> wr_ready); // R12
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R11
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !clk_en) |=> tx_busy); // R6
endmodule

bind uart_tx_engine uart_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cfg_tx_en(cfg_tx_en),
  .cfg_cts_en(cfg_cts_en), .cts_n(cts_n), .cfg_line_inv(cfg_line_inv),
  .wr_ready(wr_ready), .tx_busy(tx_busy), .txd(txd), .irq(irq)
);

// File: tb/tb_uart_tx_engine.sv
module tb_uart_tx_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b1;
  logic [7:0] cfg_divisor = 8'd0;
  logic       cfg_tx_en = 1'b1;
  logic [1:0] cfg_data_len = 2'd1;
  logic       cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0, cfg_two_stop = 1'b0;
  logic       cfg_msb_first = 1'b0, cfg_data_inv = 1'b0, cfg_line_inv = 1'b0;
  logic       cfg_cts_en = 1'b0, cfg_irq_on_done = 1'b0, cts_n = 1'b1;
  logic       wr_valid = 1'b0;
  logic [8:0] wr_data = '0;
  logic       wr_ready, txd, tx_busy, irq;

  int n_vec = 0, n_bad = 0, cycles = 0;
  int en_mode = 0;
  string cur_req = "R2";

  // behavioural model state
  int   q[$];
  bit   m_busy = 0, m_hbv = 0, m_irq = 0;
  int   m_cnt = 0;
  logic [8:0] m_hb = '0;

  uart_tx_engine dut (.*);

  always #10 clk = ~clk;

  function automatic void build(input logic [8:0] d);
    int n, bv, p;
    n = (cfg_data_len == 2'd0) ? 7 : (cfg_data_len == 2'd2) ? 9 : 8;
    p = 0;
    q.delete();
    q.push_back(0);
    for (int k = 0; k < n; k++) begin
      bv = cfg_msb_first ? int'(d[n-1-k]) : int'(d[k]);
      bv = bv ^ int'(cfg_data_inv);
      p  = p ^ bv;
      q.push_back(bv);
    end
    if (cfg_parity_en) q.push_back(p ^ int'(cfg_parity_odd));
    q.push_back(1);
    if (cfg_two_stop) q.push_back(1);
  endfunction

  always @(posedge clk) begin
    bit acc;
    if (!rst_n) begin
      m_busy = 0; m_hbv = 0; m_irq = 0; m_cnt = 0; q.delete();
    end else begin
      acc   = wr_valid && !m_hbv;
      m_irq = 0;
      if (m_busy) begin
        if (clk_en) begin
          m_cnt++;
          if (m_cnt == 16 * (int'(cfg_divisor) + 1)) begin
            m_cnt = 0;
            void'(q.pop_front());
            if (q.size() == 0) begin
              m_busy = 0;
              if (cfg_irq_on_done) m_irq = 1;
            end
          end
        end
      end else if (m_hbv && cfg_tx_en && (!cfg_cts_en || !cts_n)) begin
        build(m_hb);
        m_busy = 1; m_cnt = 0; m_hbv = 0;
        if (!cfg_irq_on_done) m_irq = 1;
      end
      if (acc) begin m_hbv = 1; m_hb = wr_data; end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // per-cycle compare, away from both edges
  always @(negedge clk) begin
    #2;
    cycles++;
    if (rst_n) begin
      check(cur_req, "txd", int'(txd), (m_busy ? q[0] : 1) ^ int'(cfg_line_inv));
      check("R12", "wr_ready", int'(wr_ready), int'(!m_hbv));
      check("R7", "tx_busy", int'(tx_busy), int'(m_busy));
      check("R11", "irq", int'(irq), int'(m_irq));
    end
  end

  always @(negedge clk) clk_en <= (en_mode == 0) ? 1'b1 : 1'($urandom % 2);

  task automatic send(input logic [8:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    while (m_busy || m_hbv) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    // R1: reset state
    check("R1", "idle txd", int'(txd), 1);
    check("R1", "ready", int'(wr_ready), 1);
    check("R1", "busy", int'(tx_busy), 0);
    check("R1", "irq", int'(irq), 0);

    // R2 R3: 8N1, LSB first, bit 8 ignored
    cur_req = "R2"; send(9'h1A5); drain();
    // R3 R4 R5: 7 data bits, even parity, two stops, m=1
    cur_req = "R3"; cfg_data_len = 2'd0; cfg_parity_en = 1; cfg_two_stop = 1; cfg_divisor = 8'd1;
    send(9'h0D3); drain();
    // R4 R8: 9 bits, odd parity, MSB first
    cur_req = "R8"; cfg_data_len = 2'd2; cfg_parity_odd = 1; cfg_two_stop = 0; cfg_divisor = 8'd0;
    cfg_msb_first = 1; send(9'h14B); drain();
    // R9 R4: data inversion with parity over inverted bits
    cur_req = "R9"; cfg_msb_first = 0; cfg_data_len = 2'd3; cfg_data_inv = 1; cfg_parity_odd = 0;
    send(9'h0F0); drain();
    // R10: whole-line inversion, toggled mid-frame
    cur_req = "R10"; cfg_data_inv = 0; cfg_line_inv = 1; send(9'h03C);
    repeat (40) @(negedge clk); cfg_line_inv = 0; drain();
    // R7: transmit disabled holds buffered word
    cur_req = "R7"; cfg_tx_en = 0; send(9'h055); repeat (60) @(negedge clk);
    cfg_tx_en = 1; drain();
    // R7: clear-to-send gating
    cfg_cts_en = 1; cts_n = 1; send(9'h0AA); repeat (60) @(negedge clk);
    cts_n = 0; drain(); cfg_cts_en = 0;
    // R11 R12: frame-end interrupt, back-to-back words, write at frame end
    cur_req = "R11"; cfg_irq_on_done = 1; cfg_parity_en = 0;
    send(9'h081); send(9'h07E); send(9'h0C3); drain();
    // R11: buffer-transfer interrupt, back-to-back
    cfg_irq_on_done = 0; send(9'h011); send(9'h122); drain();
    // R6: sparse clock enable with divisor 2
    cur_req = "R6"; en_mode = 1; cfg_divisor = 8'd2; send(9'h096); send(9'h069); drain();
    en_mode = 0; cfg_divisor = 8'd0;
    // R12: cts drops exactly as previous frame finishes
    cur_req = "R12"; cfg_cts_en = 1; cts_n = 0; send(9'h0E7);
    while (m_busy && !(q.size() == 1 && m_cnt >= 14)) @(negedge clk);
    send(9'h018); cts_n = 1; repeat (30) @(negedge clk); cts_n = 0; drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule